// File: doc/BRIEF.md
# Two-Level Lookahead Adder

This block adds two 16-bit unsigned or two's-complement operands and a carry-in in pure combinational logic. The word is cut into four 4-bit slices. Each slice works out its own internal carries directly from bit-level generate and propagate terms. Each slice then reduces itself to one block generate and one block propagate.

A separate section lookahead unit combines those four pairs with the carry-in. It produces the carry into every slice above the lowest and the final carry-out, so no carry ever travels from one slice to the next. The unit also reports the generate and propagate of the whole 16-bit word, so that a wider adder can stack several copies under a further lookahead level.

Top module: `cla_adder16`

## Requirements
- R1: For every input, the 17-bit value {carry_out, sum_out} equals op_a + op_b + carry_in.
- R2: The bit propagate of position i is op_a[i] XOR op_b[i]. word_prop is 1 exactly when all 16 bit propagates are 1.
- R3: word_gen is 1 exactly when op_a + op_b, with no carry-in, does not fit in 16 bits.
- R4: carry_out equals word_gen OR (word_prop AND carry_in). word_gen and word_prop are never 1 together.
- R5: With all-propagate operands (op_a XOR op_b = 0xFFFF), carry_in passes straight to carry_out. The sum is 0xFFFF when carry_in is 0. It is 0x0000 when carry_in is 1.
- R6: With all-generate operands (both 0xFFFF), carry_out = 1, word_gen = 1 and word_prop = 0. sum_out is 0xFFFE plus carry_in.
- R7: A carry leaving the top of any 4-bit slice enters the lowest bit of the next slice, as when 0x000F, 0x00FF, 0x0FFF or 0xFFFF is incremented.
- R8: With both operands and carry_in at zero, sum_out, carry_out, word_gen and word_prop are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum_out | output | 16 | Sum bits |
| carry_out | output | 1 | Carry out of bit 15 |
| word_gen | output | 1 | Generate of the whole 16-bit word |
| word_prop | output | 1 | Propagate of the whole 16-bit word |

## Verification
The block holds no state, so a wrong carry, block term or section term shows up at once as a wrong bit on sum_out or carry_out. It appears for the same input vector that exposes it. A bad carry into one slice corrupts the lowest sum bit of that slice and of every bit it ripples into inside the slice. A bad block term shows up only for operands whose slice pattern selects that term. For that reason the bench drives runs of ones that end at each slice boundary, the full-propagate and full-generate words, and a long pseudo-random sweep.

// File: rtl/cla_pkg.sv
// Package: shared types and default geometry for the two-level lookahead adder.
// Assumes: the slice width divides the word width.
package cla_pkg;
    localparam int unsigned DEF_WIDTH   = 16;
    localparam int unsigned DEF_SLICE_W = 4;

    // Generate/propagate pair that a slice hands to the section lookahead unit.
    typedef struct packed {
        logic gen;
        logic prop;
    } gp_pair_t;
endpackage

// File: rtl/cla_slice.sv
// Module: cla_slice
// Adds one slice of the word. The carry into each bit comes from a flattened
// sum of products of the bit generate/propagate terms and the slice carry-in,
// so nothing ripples. The slice also reports its own block generate/propagate.
// Assumes: propagate is defined as XOR, so generate and propagate never overlap.
module cla_slice
    import cla_pkg::*;
#(
    parameter int unsigned W = DEF_SLICE_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output gp_pair_t     blk
);
    logic [W-1:0] bit_g;
    logic [W-1:0] bit_p;
    logic [W-1:0] bit_c;

    // Bit-level generate and propagate.
    assign bit_g = a & b;
    assign bit_p = a ^ b;

    // Carry into each bit as a flat product-term expansion.
    always_comb begin : carry_terms
        logic acc;
        logic term;
        bit_c[0] = cin;
        for (int i = 1; i < W; i++) begin
            acc = cin;
            for (int k = 0; k < i; k++) acc = acc & bit_p[k];
            for (int j = 0; j < i; j++) begin
                term = bit_g[j];
                for (int k = j + 1; k < i; k++) term = term & bit_p[k];
                acc = acc | term;
            end
            bit_c[i] = acc;
        end
    end

    // Block generate and propagate over the whole slice.
    always_comb begin : block_terms
        logic acc;
        logic term;
        acc = 1'b0;
        for (int j = 0; j < W; j++) begin
            term = bit_g[j];
            for (int k = j + 1; k < W; k++) term = term & bit_p[k];
            acc = acc | term;
        end
        blk.gen  = acc;
        blk.prop = &bit_p;
    end

    // Sum bit is the propagate XOR the carry into that bit.
    assign sum = bit_p ^ bit_c;
endmodule

// File: rtl/cla_lookahead.sv
// Module: cla_lookahead
// Section lookahead unit. It turns N block generate/propagate pairs and the
// word carry-in into the carry into every section, the carry out of the top
// section, and the generate/propagate of all N sections together.
// Assumes: the section pairs come from slices that use XOR propagate.
module cla_lookahead #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] sec_g,
    input  logic [N-1:0] sec_p,
    input  logic         cin,
    output logic [N-1:0] sec_cin,
    output logic         cout,
    output logic         all_g,
    output logic         all_p
);
    logic [N:0] c;

    // Carry into each section boundary, expanded over all lower sections.
    always_comb begin : section_carries
        logic acc;
        logic term;
        c[0] = cin;
        for (int i = 1; i <= N; i++) begin
            acc = cin;
            for (int k = 0; k < i; k++) acc = acc & sec_p[k];
            for (int j = 0; j < i; j++) begin
                term = sec_g[j];
                for (int k = j + 1; k < i; k++) term = term & sec_p[k];
                acc = acc | term;
            end
            c[i] = acc;
        end
    end

    // Generate and propagate of the full span, for a further lookahead level.
    always_comb begin : span_terms
        logic acc;
        logic term;
        acc = 1'b0;
        for (int j = 0; j < N; j++) begin
            term = sec_g[j];
            for (int k = j + 1; k < N; k++) term = term & sec_p[k];
            acc = acc | term;
        end
        all_g = acc;
        all_p = &sec_p;
    end

    assign sec_cin = c[N-1:0];
    assign cout    = c[N];
endmodule

// File: rtl/cla_adder16.sv
// Module: cla_adder16 (top)
// Two-level lookahead adder: a row of slices and one section lookahead unit.
// Slices never pass carries to each other. Every slice carry-in comes from
// the lookahead unit.
// Assumes: WIDTH is a multiple of SLICE_W. Purely combinational, no reset.
module cla_adder16
    import cla_pkg::*;
#(
    parameter int unsigned WIDTH   = DEF_WIDTH,
    parameter int unsigned SLICE_W = DEF_SLICE_W
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_out,
    output logic             carry_out,
    output logic             word_gen,
    output logic             word_prop
);
    localparam int unsigned NSLICE = WIDTH / SLICE_W;

    gp_pair_t          slice_gp [NSLICE];
    logic [NSLICE-1:0] blk_g;
    logic [NSLICE-1:0] blk_p;
    logic [NSLICE-1:0] slice_cin;

    // One slice per SLICE_W bits, each fed by the lookahead unit.
    for (genvar s = 0; s < NSLICE; s++) begin : g_slice
        cla_slice #(.W(SLICE_W)) u_slice (
            .a   (op_a[s*SLICE_W +: SLICE_W]),
            .b   (op_b[s*SLICE_W +: SLICE_W]),
            .cin (slice_cin[s]),
            .sum (sum_out[s*SLICE_W +: SLICE_W]),
            .blk (slice_gp[s])
        );
        assign blk_g[s] = slice_gp[s].gen;
        assign blk_p[s] = slice_gp[s].prop;
    end

    cla_lookahead #(.N(NSLICE)) u_lookahead (
        .sec_g   (blk_g),
        .sec_p   (blk_p),
        .cin     (carry_in),
        .sec_cin (slice_cin),
        .cout    (carry_out),
        .all_g   (word_gen),
        .all_p   (word_prop)
    );
endmodule

// File: rtl/cla_adder16_chk.sv
// Module: cla_adder16_chk
// Port-level checker bound into cla_adder16. It compares the lookahead
// result with plain arithmetic and checks that the span terms are consistent.
// Assumes: combinational logic has settled when each check runs.
module cla_adder16_chk #(
    parameter int unsigned WIDTH   = 16,
    parameter int unsigned SLICE_W = 4
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             carry_in,
    input logic [WIDTH-1:0] sum_out,
    input logic             carry_out,
    input logic             word_gen,
    input logic             word_prop
);
    logic [WIDTH:0] ref_total;
    logic [WIDTH:0] ref_nocin;

    // Reference arithmetic, independent of the lookahead structure.
    assign ref_total = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};
    assign ref_nocin = {1'b0, op_a} + {1'b0, op_b};

    // Consistency checks on every settled input change.
    always_comb begin
        assert_sum_R1:   assert ({carry_out, sum_out} == ref_total);
        assert_prop_R2:  assert (word_prop == &(op_a ^ op_b));
        assert_gen_R3:   assert (word_gen == ref_nocin[WIDTH]);
        assert_cout_R4:  assert (carry_out == (word_gen | (word_prop & carry_in)));
        assert_excl_R4:  assert (!(word_gen && word_prop));
    end
endmodule

bind cla_adder16 cla_adder16_chk #(.WIDTH(WIDTH), .SLICE_W(SLICE_W)) u_chk (.*);

// File: tb/cla_adder16_tb.sv
// Bench: directed scenarios for cla_adder16, one task per scenario.
module cla_adder16_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] op_a = '0;
    logic [15:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic [15:0] sum_out;
    logic        carry_out;
    logic        word_gen;
    logic        word_prop;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    cla_adder16 u_dut (
        .op_a      (op_a),
        .op_b      (op_b),
        .carry_in  (carry_in),
        .sum_out   (sum_out),
        .carry_out (carry_out),
        .word_gen  (word_gen),
        .word_prop (word_prop)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Compare one field with its expected value.
    task automatic check(input string req, input string what, input logic [16:0] act, input logic [16:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h (a=%h b=%h cin=%b)",
                     req, what, act, exp, op_a, op_b, carry_in);
        end
    endtask

    // Drive one vector on a rising edge, sample half a period later.
    task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic c);
        @(posedge clk);
        op_a = a; op_b = b; carry_in = c;
        #(CLK_PERIOD/2);
    endtask

    // Full check of one vector against arithmetic worked out in the bench.
    task automatic check_vec(input string req, input logic [15:0] a, input logic [15:0] b, input logic c);
        logic [16:0] tot;
        logic [16:0] nocin;
        apply(a, b, c);
        tot   = {1'b0, a} + {1'b0, b} + {16'd0, c};
        nocin = {1'b0, a} + {1'b0, b};
        check(req, "sum/cout R1", {carry_out, sum_out}, tot);
        check(req, "word_prop R2", {16'd0, word_prop}, {16'd0, &(a ^ b)});
        check(req, "word_gen R3", {16'd0, word_gen}, {16'd0, nocin[16]});
        check(req, "cout R4", {16'd0, carry_out}, {16'd0, nocin[16] | (&(a ^ b) & c)});
    endtask

    // R8: zero operands, which is also the state right after reset.
    task automatic t_zero();
        apply(16'h0000, 16'h0000, 1'b0);
        check("R8", "sum", {1'b0, sum_out}, 17'd0);
        check("R8", "cout", {16'd0, carry_out}, 17'd0);
        check("R8", "gen", {16'd0, word_gen}, 17'd0);
        check("R8", "prop", {16'd0, word_prop}, 17'd0);
    endtask

    // R5: all-propagate words pass the carry-in straight through.
    task automatic t_propagate();
        apply(16'hA5C3, 16'h5A3C, 1'b0);
        check("R5", "sum cin0", {carry_out, sum_out}, {1'b0, 16'hFFFF});
        check("R5", "prop", {16'd0, word_prop}, 17'd1);
        apply(16'hA5C3, 16'h5A3C, 1'b1);
        check("R5", "sum cin1", {carry_out, sum_out}, {1'b1, 16'h0000});
        apply(16'hFFFF, 16'h0000, 1'b1);
        check("R5", "sum ffff+0+1", {carry_out, sum_out}, {1'b1, 16'h0000});
        check_vec("R5", 16'h0000, 16'hFFFF, 1'b0);
    endtask

    // R6: all-generate words.
    task automatic t_generate();
        for (int c = 0; c < 2; c++) begin
            apply(16'hFFFF, 16'hFFFF, c[0]);
            check("R6", "sum", {1'b0, sum_out}, {1'b0, 16'hFFFE + {15'd0, c[0]}});
            check("R6", "cout", {16'd0, carry_out}, 17'd1);
            check("R6", "gen", {16'd0, word_gen}, 17'd1);
            check("R6", "prop", {16'd0, word_prop}, 17'd0);
        end
    endtask

    // R7: a carry that fills a slice enters the next one.
    task automatic t_boundaries();
        apply(16'h000F, 16'h0001, 1'b0);
        check("R7", "slice0->1", {carry_out, sum_out}, {1'b0, 16'h0010});
        apply(16'h00FF, 16'h0000, 1'b1);
        check("R7", "slice1->2", {carry_out, sum_out}, {1'b0, 16'h0100});
        apply(16'h0FFF, 16'h0001, 1'b0);
        check("R7", "slice2->3", {carry_out, sum_out}, {1'b0, 16'h1000});
        apply(16'hFFFF, 16'h0001, 1'b0);
        check("R7", "slice3->out", {carry_out, sum_out}, {1'b1, 16'h0000});
        for (int s = 0; s < 4; s++) begin
            check_vec("R7", 16'h0008 << (4*s), 16'h0008 << (4*s), 1'b0);
            check_vec("R7", 16'h0007 << (4*s), 16'h0009 << (4*s), 1'b1);
        end
    endtask

    // R1-R4: directed mixed words, then a pseudo-random sweep.
    task automatic t_sweep();
        logic [31:0] x;
        check_vec("R1", 16'h1234, 16'h4321, 1'b0);
        check_vec("R1", 16'h7FFF, 16'h0001, 1'b0);
        check_vec("R3", 16'h8000, 16'h8000, 1'b0);
        check_vec("R4", 16'hF0F0, 16'h0F0F, 1'b1);
        check_vec("R2", 16'hFFF0, 16'h000E, 1'b1);
        x = 32'h1BADF00D;
        for (int i = 0; i < 2000; i++) begin
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            check_vec("R1", x[15:0], x[31:16], x[7]);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_zero();
        t_propagate();
        t_generate();
        t_boundaries();
        t_sweep();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule